// File: doc/BRIEF.md
# Shared-Engine Descriptor Arbiter with Group Locking

This block decides which of several DMA pipes may hand its next descriptor to a single shared processing engine. Every pipe has a doorbell that raises its count of waiting descriptors and a static group ID. When the engine is idle, the arbiter picks one eligible pipe, issues a one-cycle grant, and takes that pipe's count down by one. The engine then reports completion with a pulse that carries the finished descriptor's 16-bit flags word, and the arbiter is free to grant again.

A command descriptor can claim the engine for its pipe group. While that claim holds, pipes of other groups are frozen: their doorbells are still counted, but they get no grants. A later command descriptor that releases the claim makes every pipe eligible again. The arbiter exposes the lock state and the owning group so the rest of the engine can watch them.

Top module: `desc_lock_arb`

## Requirements
- R1: After reset no grant is issued, `locked_o` is 0, `lock_group_o` is 0 and every pending count is zero, so pipes are granted only after doorbells arrive.
- R2: `done_flags_i` arrives little-endian. The corrected word is `{raw[7:0], raw[15:8]}`, and in it bit 11 is command, bit 10 is lock and bit 9 is release. A raw value of 16'h0C00 therefore carries no command bit.
- R3: Only one descriptor is in flight at a time. `grant_valid_o` is a one-cycle pulse, and no new grant follows until a `done_i` pulse completes the current descriptor.
- R4: Eligible pipes with pending descriptors are granted round-robin. The search starts at the pipe after the last one granted, counting upward and wrapping.
- R5: Each doorbell adds one pending descriptor and each grant removes one. A doorbell and a grant for the same pipe in the same cycle leave its count unchanged.
- R6: A pending count saturates at 2^CNT_W-1. Further doorbells are dropped, so that many grants follow for the pipe.
- R7: When a command descriptor with the lock bit and without the release bit completes, `locked_o` becomes 1 and `lock_group_o` takes the group of the pipe that was granted.
- R8: While locked, only pipes whose group equals `lock_group_o` are granted. Doorbells on blocked pipes keep counting and are all granted after release.
- R9: When a command descriptor with the release bit completes, `locked_o` returns to 0 and `lock_group_o` to 0. The very next grant decision treats every pipe as eligible.
- R10: Lock and release bits on a descriptor whose command bit is clear have no effect on the lock state.
- R11: A command descriptor carrying both lock and release leaves the arbiter unlocked after it completes.
- R12: A `done_i` pulse while no descriptor is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| doorbell_i | input | NUM_PIPES | One pulse per pipe adds one pending descriptor |
| pipe_group_i | input | NUM_PIPES*GROUP_W | Group ID of each pipe, pipe i at bits [i*GROUP_W +: GROUP_W] |
| done_i | input | 1 | Engine finished the granted descriptor |
| done_flags_i | input | 16 | Raw little-endian flags of the finished descriptor |
| grant_valid_o | output | 1 | One-cycle grant pulse |
| grant_pipe_o | output | PIPE_W | Pipe that was granted |
| locked_o | output | 1 | Engine is claimed by one group |
| lock_group_o | output | GROUP_W | Group holding the claim, 0 when unlocked |

## Verification
Two events can land in the same cycle: a doorbell and a grant on the same pipe. The bench holds one pipe's doorbell high across three edges, so that the grant lands on the middle edge. It then requires exactly three grants for three doorbells, no more and no fewer. The second collision is a lock completion alongside doorbells queued on blocked pipes. There the bench demands that no foreign grant appears during the lock and that the full backlog drains in round-robin order on the first decisions after release.

// File: rtl/desc_lock_arb_pkg.sv
package desc_lock_arb_pkg;
  localparam int FLAG_W      = 16;
  localparam int FLG_CMD     = 11;
  localparam int FLG_LOCK    = 10;
  localparam int FLG_RELEASE = 9;

  function automatic logic [FLAG_W-1:0] fix_order(input logic [FLAG_W-1:0] raw);
    return {raw[7:0], raw[15:8]};
  endfunction
endpackage

// File: rtl/pend_cnt.sv
module pend_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign nz_o = (cnt_q != '0);

  AST_DEC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && dec_i |=> cnt_q == $past(cnt_q)); // R5
  AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == MAX && !dec_i |=> cnt_q == MAX); // R6
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N      = 4,
  parameter int PIPE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      elig_i,
  input  logic [PIPE_W-1:0] ptr_i,
  output logic              valid_o,
  output logic [PIPE_W-1:0] sel_o
);
  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % N;
      if (!valid_o && elig_i[idx]) begin
        valid_o = 1'b1;
        sel_o   = PIPE_W'(idx);
      end
    end
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[sel_o]); // R4
  AST_PICK_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i != '0) |-> valid_o); // R4
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import desc_lock_arb_pkg::*;
#(
  parameter int GROUP_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [FLAG_W-1:0]  flags_raw_i,
  input  logic [GROUP_W-1:0] group_i,
  output logic               locked_o,
  output logic [GROUP_W-1:0] group_o
);
  logic [FLAG_W-1:0] flg;
  logic is_cmd, want_lock, want_rel;

  assign flg       = fix_order(flags_raw_i);
  assign is_cmd    = flg[FLG_CMD];
  assign want_lock = flg[FLG_LOCK];
  assign want_rel  = flg[FLG_RELEASE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      group_o  <= '0;
    end else if (done_i && is_cmd) begin
      if (want_rel) begin
        locked_o <= 1'b0;
        group_o  <= '0;
      end else if (want_lock) begin
        locked_o <= 1'b1;
        group_o  <= group_i;
      end
    end
  end

  AST_NEED_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !flags_raw_i[3] |=> locked_o == $past(locked_o)); // R10
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && flags_raw_i[3] && flags_raw_i[1] |=> !locked_o); // R11
  AST_LOCK_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && flags_raw_i[3] && flags_raw_i[2] && !flags_raw_i[1]
    |=> locked_o && group_o == $past(group_i)); // R7
endmodule

// File: rtl/desc_lock_arb.sv
module desc_lock_arb
  import desc_lock_arb_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int GROUP_W   = 2,
  parameter int CNT_W     = 4,
  parameter int PIPE_W    = $clog2(NUM_PIPES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PIPES-1:0]         doorbell_i,
  input  logic [NUM_PIPES*GROUP_W-1:0] pipe_group_i,
  input  logic                         done_i,
  input  logic [FLAG_W-1:0]            done_flags_i,
  output logic                         grant_valid_o,
  output logic [PIPE_W-1:0]            grant_pipe_o,
  output logic                         locked_o,
  output logic [GROUP_W-1:0]           lock_group_o
);
  localparam logic [PIPE_W-1:0] LAST = PIPE_W'(NUM_PIPES - 1);

  logic [NUM_PIPES-1:0] nz, elig, dec;
  logic                 busy_q, pick_valid, gnt_fire, done_fire;
  logic [PIPE_W-1:0]    pick_sel, cur_pipe_q, rr_ptr_q;
  logic [GROUP_W-1:0]   cur_group;

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    assign elig[i] = nz[i] &&
      (!locked_o || pipe_group_i[i*GROUP_W +: GROUP_W] == lock_group_o);
    assign dec[i]  = gnt_fire && (pick_sel == PIPE_W'(i));
    pend_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (doorbell_i[i]),
      .dec_i  (dec[i]),
      .nz_o   (nz[i])
    );
  end

  rr_pick #(.N(NUM_PIPES), .PIPE_W(PIPE_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (elig),
    .ptr_i   (rr_ptr_q),
    .valid_o (pick_valid),
    .sel_o   (pick_sel)
  );

  assign gnt_fire  = !busy_q && pick_valid;
  assign done_fire = busy_q && done_i;
  assign cur_group = pipe_group_i[cur_pipe_q*GROUP_W +: GROUP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q        <= 1'b0;
      cur_pipe_q    <= '0;
      rr_ptr_q      <= '0;
      grant_valid_o <= 1'b0;
      grant_pipe_o  <= '0;
    end else begin
      grant_valid_o <= gnt_fire;
      if (gnt_fire) begin
        busy_q       <= 1'b1;
        cur_pipe_q   <= pick_sel;
        grant_pipe_o <= pick_sel;
        rr_ptr_q     <= (pick_sel == LAST) ? '0 : pick_sel + 1'b1;
      end else if (done_fire) begin
        busy_q <= 1'b0;
      end
    end
  end

  lock_fsm #(.GROUP_W(GROUP_W)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done_fire),
    .flags_raw_i (done_flags_i),
    .group_i     (cur_group),
    .locked_o    (locked_o),
    .group_o     (lock_group_o)
  );

  AST_GNT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |=> !grant_valid_o); // R3
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i |=> !grant_valid_o); // R3
  AST_LOCK_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && locked_o
    |-> pipe_group_i[grant_pipe_o*GROUP_W +: GROUP_W] == lock_group_o); // R8
  AST_IDLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && done_i |=> locked_o == $past(locked_o)); // R12
endmodule

// File: tb/desc_lock_arb_test.sv
module desc_lock_arb_test;
  localparam int N = 4;
  localparam logic [15:0] F_CMD = 16'h0800;
  localparam logic [15:0] F_LCK = 16'h0400;
  localparam logic [15:0] F_REL = 16'h0200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] doorbell = '0;
  logic [7:0] groups = {2'd2, 2'd1, 2'd0, 2'd0};
  logic       done = 1'b0;
  logic [15:0] flags = '0;
  logic       gnt_v;
  logic [1:0] gnt_p;
  logic       locked;
  logic [1:0] lgrp;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  desc_lock_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .doorbell_i(doorbell), .pipe_group_i(groups),
    .done_i(done), .done_flags_i(flags), .grant_valid_o(gnt_v),
    .grant_pipe_o(gnt_p), .locked_o(locked), .lock_group_o(lgrp)
  );

  always #10 clk = ~clk;

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic ring(input logic [3:0] m);
    @(negedge clk); doorbell = m;
    @(negedge clk); doorbell = '0;
  endtask

  task automatic expect_grant(input int exp, input string req);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (gnt_v) seen = 1;
    end
    chk(seen && int'(gnt_p) == exp, req, seen ? int'(gnt_p) : -1, exp);
  endtask

  task automatic expect_none(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gnt_v) seen = 1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic complete_raw(input logic [15:0] raw);
    @(negedge clk); done = 1'b1; flags = raw;
    @(negedge clk); done = 1'b0; flags = '0;
  endtask

  task automatic complete(input logic [15:0] f);
    complete_raw({f[7:0], f[15:8]});
  endtask

  task automatic t_reset();
    chk(!gnt_v, "R1 grant", int'(gnt_v), 0);
    chk(!locked, "R1 locked", int'(locked), 0);
    chk(lgrp == 0, "R1 group", int'(lgrp), 0);
    expect_none(5, "R1 no grant without doorbell");
  endtask

  task automatic t_round_robin();
    ring(4'b1111);
    for (int p = 0; p < N; p++) begin
      expect_grant(p, "R4 rr order");
      if (p == 0) expect_none(4, "R3 held until done");
      complete(16'h0);
    end
    expect_none(8, "R5 all drained");
  endtask

  task automatic t_overlap();
    @(negedge clk); doorbell = 4'b0010;
    @(negedge clk);
    @(negedge clk);
    chk(gnt_v && gnt_p == 2'd1, "R5 grant during doorbell", int'(gnt_p), 1);
    @(negedge clk); doorbell = '0;
    complete(16'h0);
    expect_grant(1, "R5 second of three");
    complete(16'h0);
    expect_grant(1, "R5 third of three");
    complete(16'h0);
    expect_none(8, "R5 exactly three grants");
  endtask

  task automatic t_saturate();
    ring(4'b1000);
    expect_grant(3, "R6 occupy");
    @(negedge clk); doorbell = 4'b0001;
    for (int i = 0; i < 20; i++) @(negedge clk);
    doorbell = '0;
    complete(16'h0);
    for (int i = 0; i < 15; i++) begin
      expect_grant(0, "R6 saturated grants");
      complete(16'h0);
    end
    expect_none(8, "R6 no grant past 15");
  endtask

  task automatic t_lock();
    ring(4'b0100);
    expect_grant(2, "R7 locker granted");
    ring(4'b1011);
    ring(4'b0100);
    ring(4'b0100);
    complete(F_CMD | F_LCK);
    chk(locked, "R7 locked", int'(locked), 1);
    chk(lgrp == 2'd1, "R7 owner group", int'(lgrp), 1);
    expect_grant(2, "R8 only own group");
    complete(16'h0);
    expect_grant(2, "R8 only own group");
    complete(16'h0);
    expect_none(10, "R8 blocked pipes idle");
    ring(4'b0001);
    expect_none(5, "R8 doorbell while blocked");
    ring(4'b0100);
    expect_grant(2, "R8 own group pre-release");
    complete(F_CMD | F_REL);
    chk(!locked, "R9 released", int'(locked), 0);
    chk(lgrp == 0, "R9 group cleared", int'(lgrp), 0);
    expect_grant(3, "R9 backlog p3");
    complete(16'h0);
    expect_grant(0, "R9 backlog p0");
    complete(16'h0);
    expect_grant(1, "R9 backlog p1");
    complete(16'h0);
    expect_grant(0, "R8 retained p0");
    complete(16'h0);
    expect_none(8, "R8 backlog exact");
  endtask

  task automatic t_no_cmd();
    ring(4'b1000);
    expect_grant(3, "R10 setup");
    complete(F_LCK);
    chk(!locked, "R10 lock without cmd", int'(locked), 0);
    ring(4'b0101);
    expect_grant(0, "R10 others still served");
    complete(16'h0);
    expect_grant(2, "R10 others still served");
    complete(16'h0);
  endtask

  task automatic t_both();
    ring(4'b0010);
    expect_grant(1, "R11 setup");
    complete(F_CMD | F_LCK | F_REL);
    chk(!locked, "R11 lock+release", int'(locked), 0);
    ring(4'b1100);
    expect_grant(2, "R11 open to all");
    complete(16'h0);
    expect_grant(3, "R11 open to all");
    complete(16'h0);
  endtask

  task automatic t_byte_order();
    ring(4'b0001);
    expect_grant(0, "R2 setup");
    complete_raw(16'h0C00);
    chk(!locked, "R2 unswapped not cmd", int'(locked), 0);
    ring(4'b0100);
    expect_grant(2, "R2 setup2");
    complete_raw(16'h000C);
    chk(locked && lgrp == 2'd1, "R2 swapped lock", int'(lgrp), 1);
    ring(4'b0100);
    expect_grant(2, "R2 release setup");
    complete_raw(16'h000A);
    chk(!locked, "R2 swapped release", int'(locked), 0);
  endtask

  task automatic t_idle_done();
    expect_none(3, "R12 idle");
    complete(F_CMD | F_LCK);
    chk(!locked, "R12 idle done ignored", int'(locked), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_overlap();
    t_saturate();
    t_lock();
    t_no_cmd();
    t_both();
    t_byte_order();
    t_idle_done();
    finish_up();
  end
endmodule